// File: doc/BRIEF.md
# Prioritised Interrupt Collector with Non-Maskable Path and Countdown Source

This block gathers interrupt requests from a set of external devices and from an internal countdown timer, and presents one request at a time to a processor. Each source keeps a pending flag that is set on the source's rising edge, or when the timer expires. The flag stays set until the processor acknowledges that source by its identifier. A request that arrives while another one is being served is therefore held and reported later.

The processor sees a single request line and an identifier. Among the maskable sources the lowest index wins. Each maskable source has its own mask bit, and a global enable gates all of them together. A separate non-maskable input has its own pending flag and a reserved identifier. It ignores the global enable and the mask bits, and it outranks every other source. The timer is loaded with a delay. It counts down once per clock, raises its source when it expires, and then stays stopped until it is loaded again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is held and on leaving reset, `irq_o` is low, `irq_id_o` is zero, no source is pending and the timer is idle.
- R2: A low-to-high transition on `req_i[k]` sets the pending flag of device k at the clock edge where the high level is first sampled, and `irq_id_o` shows k from that edge on. A level held high does not set the flag again. Identifiers are: 0 to NUM_DEV-1 for the devices, NUM_DEV for the timer, NUM_DEV+1 for the non-maskable input.
- R3: A pending flag stays set until an edge on which `ack_i` is high and `ack_id_i` equals its identifier. An acknowledge that carries another identifier leaves it set. Once the served flag clears, the next eligible source is reported.
- R4: When several maskable sources are pending, unmasked and globally enabled, the one with the lowest identifier is reported.
- R5: While `gie_i` is low and no non-maskable request is pending, `irq_o` stays low. Maskable pending flags are kept and are reported once `gie_i` returns high.
- R6: Mask bit `mask_i[k]` = 1 hides source k from reporting but does not clear its pending flag. The source is reported as soon as its mask bit returns to 0.
- R7: A rising edge on `nmi_i` pends the non-maskable source. It is then reported with identifier NUM_DEV+1 whatever the values of `gie_i`, `mask_i` and the other pending flags, until it is acknowledged with that identifier.
- R8: A one-cycle `tmr_load_i` pulse with value V starts the countdown. The timer's pending flag is set max(V,1) clock edges after the loading edge. The timer then stops until the next load, and a load during a countdown restarts it with the new value.
- R9: When a new rising edge of a source and an acknowledge of that same source fall on the same edge, the pending flag ends up set.
- R10: Whenever `irq_o` is low, `irq_id_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_DEV | Device request lines, rising-edge sensitive |
| mask_i | input | NUM_DEV+1 | Per-source mask, bit NUM_DEV is the timer; 1 hides the source |
| gie_i | input | 1 | Global enable for all maskable sources |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| tmr_load_i | input | 1 | Loads the countdown and starts it |
| tmr_value_i | input | TMR_W | Delay in clock cycles for the countdown |
| ack_i | input | 1 | Acknowledge strobe |
| ack_id_i | input | ID_W | Identifier of the source being acknowledged |
| irq_o | output | 1 | Request to the processor |
| irq_id_o | output | ID_W | Identifier of the reported source, zero when idle |

## Verification
A pending flag that is wrongly held or dropped shows at the ports within one clock. A lost flag hides a source that should appear once the winning source has been acknowledged. A flag that never clears keeps reporting the same identifier after its acknowledge. A wrong priority or gating decision is combinational from the pending state, so it shows on the very edge that sets up the case. The bench sweeps every mask pattern under both global-enable values with all sources pending. A countdown that is off by one shows as the timer identifier appearing one edge early or late. The bench measures this for several load values, including 0 and 1.

// File: rtl/pic_pkg.sv
package pic_pkg;

   // identifier width able to code every source plus the reserved NMI code
   function automatic int id_bits(input int n_src);
      return (n_src + 1 > 1) ? $clog2(n_src + 1) : 1;
   endfunction

endpackage

// File: rtl/pic_timer.sv
module pic_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] value_i,
   output logic             fire_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             last_tick;

   assign last_tick = run_q && (cnt_q <= CNT_W'(1));
   assign fire_o    = last_tick && !load_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load_i) begin
         cnt_q <= value_i;
         run_q <= 1'b1;
      end else if (last_tick) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (run_q) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

endmodule

// File: rtl/pic_pend.sv
module pic_pend #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flag_q <= 1'b0;
         else if (set_i[i])
            flag_q <= 1'b1;
         else if (clr_i[i])
            flag_q <= 1'b0;
      end
      assign pend_o[i] = flag_q;
   end

endmodule

// File: rtl/pic_select.sv
module pic_select #(
   parameter int N    = 5,
   parameter int ID_W = 3
) (
   input  logic [N-1:0]    vec_i,
   output logic            any_o,
   output logic [ID_W-1:0] id_o
);

   always_comb begin
      any_o = 1'b0;
      id_o  = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) begin
            any_o = 1'b1;
            id_o  = ID_W'(i);
         end
      end
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int NUM_DEV   = 4,
   parameter int TMR_W     = 16,
   parameter bit HAS_TIMER = 1'b1,
   localparam int NSRC     = NUM_DEV + 1,
   localparam int NMI_ID   = NSRC,
   localparam int ID_W     = pic_pkg::id_bits(NSRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_DEV-1:0] req_i,
   input  logic [NSRC-1:0]    mask_i,
   input  logic               gie_i,
   input  logic               nmi_i,
   input  logic               tmr_load_i,
   input  logic [TMR_W-1:0]   tmr_value_i,
   input  logic               ack_i,
   input  logic [ID_W-1:0]    ack_id_i,
   output logic               irq_o,
   output logic [ID_W-1:0]    irq_id_o
);

   if (NUM_DEV < 1) begin : g_bad_dev
      $error("prio_irq_ctrl: NUM_DEV must be at least 1");
   end
   if (TMR_W < 1) begin : g_bad_tmr
      $error("prio_irq_ctrl: TMR_W must be at least 1");
   end

   logic [NUM_DEV:0] ext_now;
   logic [NUM_DEV:0] edge_q;
   logic [NUM_DEV:0] rise;
   logic             tmr_fire;
   logic [NSRC:0]    set_vec;
   logic [NSRC:0]    clr_vec;
   logic [NSRC:0]    pend_q;
   logic [NSRC-1:0]  eligible;
   logic             sel_any;
   logic [ID_W-1:0]  sel_id;

   // edge detection on device lines and the non-maskable line
   assign ext_now = {nmi_i, req_i};
   assign rise    = ext_now & ~edge_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         edge_q <= '0;
      else
         edge_q <= ext_now;
   end

   if (HAS_TIMER) begin : g_timer
      pic_timer #(.CNT_W(TMR_W)) u_tmr (
         .clk     (clk),
         .rst_n   (rst_n),
         .load_i  (tmr_load_i),
         .value_i (tmr_value_i),
         .fire_o  (tmr_fire)
      );
   end else begin : g_no_timer
      assign tmr_fire = 1'b0;
   end

   assign set_vec = {rise[NUM_DEV], tmr_fire, rise[NUM_DEV-1:0]};

   always_comb begin
      for (int i = 0; i <= NSRC; i++)
         clr_vec[i] = ack_i && (ack_id_i == ID_W'(i));
   end

   pic_pend #(.N(NSRC + 1)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec),
      .clr_i  (clr_vec),
      .pend_o (pend_q)
   );

   assign eligible = pend_q[NSRC-1:0] & ~mask_i & {NSRC{gie_i}};

   pic_select #(.N(NSRC), .ID_W(ID_W)) u_sel (
      .vec_i (eligible),
      .any_o (sel_any),
      .id_o  (sel_id)
   );

   always_comb begin
      if (pend_q[NSRC]) begin
         irq_o    = 1'b1;
         irq_id_o = ID_W'(NMI_ID);
      end else begin
         irq_o    = sel_any;
         irq_id_o = sel_any ? sel_id : '0;
      end
   end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int NUM_DEV = 4,
   localparam int NSRC   = NUM_DEV + 1,
   localparam int ID_W   = pic_pkg::id_bits(NSRC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_DEV-1:0] req_i,
   input logic               nmi_i,
   input logic               gie_i,
   input logic               ack_i,
   input logic [ID_W-1:0]    ack_id_i,
   input logic               irq_o,
   input logic [ID_W-1:0]    irq_id_o,
   input logic [NSRC:0]      pend_q
);

   logic             past_ok;
   logic [NUM_DEV:0] prev_ext;
   logic [NUM_DEV:0] ext_now;
   logic [NUM_DEV:0] pend_ext;
   logic [NSRC:0]    ack_vec;

   assign ext_now  = {nmi_i, req_i};
   assign pend_ext = {pend_q[NSRC], pend_q[NUM_DEV-1:0]};

   always_comb begin
      for (int i = 0; i <= NSRC; i++)
         ack_vec[i] = ack_i && (ack_id_i == ID_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         past_ok  <= 1'b0;
         prev_ext <= '0;
      end else begin
         past_ok  <= 1'b1;
         prev_ext <= ext_now;
      end
   end

   assert_gie_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!gie_i && !pend_q[NSRC]) |-> !irq_o);

   assert_nmi_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[NSRC] |-> (irq_o && irq_id_o == ID_W'(NSRC)));

   assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o |-> (irq_id_o == '0));

   assert_reported_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> pend_q[irq_id_o]);

   assert_pend_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (($past(pend_q) & ~$past(ack_vec) & ~pend_q) == '0));

   assert_rise_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (($past(ext_now) & ~$past(prev_ext) & ~pend_ext) == '0));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NUM_DEV(NUM_DEV)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_i    (req_i),
   .nmi_i    (nmi_i),
   .gie_i    (gie_i),
   .ack_i    (ack_i),
   .ack_id_i (ack_id_i),
   .irq_o    (irq_o),
   .irq_id_o (irq_id_o),
   .pend_q   (pend_q)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;

   localparam int ND = 4;
   localparam int NS = ND + 1;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [ND-1:0] req = '0;
   logic [NS-1:0] mask = '0;
   logic          gie = 1'b0;
   logic          nmi = 1'b0;
   logic          tld = 1'b0;
   logic [15:0]   tval = '0;
   logic          ack = 1'b0;
   logic [IW-1:0] ackid = '0;
   logic          irq;
   logic [IW-1:0] irq_id;

   int n_checks = 0;
   int n_errors = 0;

   // requirement-level model state
   logic [NS:0]   m_pend = '0;
   logic [ND:0]   m_prev = '0;
   int            m_tcnt = 0;
   logic          m_trun = 1'b0;

   always #5 clk = ~clk;

   prio_irq_ctrl #(.NUM_DEV(ND), .TMR_W(16)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req),
      .mask_i      (mask),
      .gie_i       (gie),
      .nmi_i       (nmi),
      .tmr_load_i  (tld),
      .tmr_value_i (tval),
      .ack_i       (ack),
      .ack_id_i    (ackid),
      .irq_o       (irq),
      .irq_id_o    (irq_id)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // one clock: update the model at the edge, compare outputs at the falling edge
   task automatic cyc(input string tag);
      logic [ND:0] ext;
      logic [NS:0] setv;
      logic [NS:0] clrv;
      logic        fire;
      logic [NS-1:0] el;
      int e_irq;
      int e_id;
      @(posedge clk);
      ext  = {nmi, req};
      fire = 1'b0;
      if (tld) begin
         m_tcnt = int'(tval);
         m_trun = 1'b1;
      end else if (m_trun) begin
         if (m_tcnt <= 1) begin
            m_trun = 1'b0;
            m_tcnt = 0;
            fire   = 1'b1;
         end else begin
            m_tcnt--;
         end
      end
      setv = {ext[ND] & ~m_prev[ND], fire, ext[ND-1:0] & ~m_prev[ND-1:0]};
      clrv = '0;
      if (ack && int'(ackid) <= NS) clrv[ackid] = 1'b1;
      m_pend = (m_pend & ~clrv) | setv;
      m_prev = ext;
      @(negedge clk);
      e_irq = 0;
      e_id  = 0;
      if (m_pend[NS]) begin
         e_irq = 1;
         e_id  = NS;
      end else begin
         el = m_pend[NS-1:0] & ~mask & {NS{gie}};
         for (int i = NS - 1; i >= 0; i--)
            if (el[i]) begin
               e_irq = 1;
               e_id  = i;
            end
      end
      check(tag, "irq_o", int'(irq), e_irq);
      check(tag, "irq_id_o", int'(irq_id), e_id);
   endtask

   task automatic ack_src(input int id, input string tag);
      ack   = 1'b1;
      ackid = IW'(id);
      cyc(tag);
      ack   = 1'b0;
   endtask

   initial begin
      #2_000_000;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "irq_o in reset", int'(irq), 0);
      check("R1", "irq_id_o in reset", int'(irq_id), 0);
      rst_n = 1'b1;
      gie   = 1'b1;
      cyc("R1");

      // R2: each device edge reported with its own id; held level does not re-pend
      for (int k = 0; k < ND; k++) begin
         req[k] = 1'b1;
         cyc("R2");
         check("R2", "id after edge", int'(irq_id), k);
         ack_src(k, "R3");
         cyc("R2");
         check("R2", "held level no re-pend", int'(irq), 0);
         req[k] = 1'b0;
         cyc("R2");
      end

      // R3: buffering and acknowledge matching
      req = 4'b0110;
      cyc("R3");
      check("R3", "first winner", int'(irq_id), 1);
      ack_src(3, "R3");
      check("R3", "wrong-id ack ignored", int'(irq_id), 1);
      ack_src(1, "R3");
      check("R3", "next source after ack", int'(irq_id), 2);
      ack_src(2, "R3");
      check("R3", "all served", int'(irq), 0);
      req = '0;
      cyc("R3");

      // R4, R5, R6: all maskable sources pending, sweep masks and global enable
      req  = '1;
      tld  = 1'b1;
      tval = 16'd0;
      cyc("R4");
      tld  = 1'b0;
      cyc("R8");
      for (int g = 0; g < 2; g++) begin
         for (int m = 0; m < (1 << NS); m++) begin
            gie  = g[0];
            mask = NS'(m);
            cyc(g == 0 ? "R5" : (m == 0 ? "R4" : "R6"));
         end
      end
      gie  = 1'b1;
      mask = '0;
      cyc("R6");
      check("R6", "pending kept through masking", int'(irq_id), 0);
      for (int k = 0; k < NS; k++) ack_src(k, "R3");
      req = '0;
      cyc("R3");

      // R7: non-maskable beats disable, masks and pending sources
      gie    = 1'b0;
      mask   = '1;
      req[0] = 1'b1;
      cyc("R5");
      nmi = 1'b1;
      cyc("R7");
      check("R7", "nmi id", int'(irq_id), NS);
      gie  = 1'b1;
      mask = '0;
      cyc("R7");
      check("R7", "nmi outranks device", int'(irq_id), NS);
      ack_src(0, "R7");
      check("R7", "device ack leaves nmi", int'(irq_id), NS);
      ack_src(NS, "R7");
      check("R7", "nmi cleared", int'(irq), 0);
      nmi    = 1'b0;
      req[0] = 1'b0;
      cyc("R7");

      // R8: countdown length for several load values
      foreach (tval_list[i]) begin
         int n;
         tld  = 1'b1;
         tval = 16'(tval_list[i]);
         cyc("R8");
         tld = 1'b0;
         n   = 0;
         while (!irq && n < 200) begin
            cyc("R8");
            n++;
         end
         check("R8", "countdown edges", n, (tval_list[i] < 1) ? 1 : tval_list[i]);
         check("R8", "timer id", int'(irq_id), ND);
         ack_src(ND, "R8");
         repeat (8) cyc("R8");
      end
      // reload during a countdown restarts it
      tld  = 1'b1;
      tval = 16'd10;
      cyc("R8");
      tld = 1'b0;
      repeat (4) cyc("R8");
      tld  = 1'b1;
      tval = 16'd3;
      cyc("R8");
      tld = 1'b0;
      cyc("R8");
      cyc("R8");
      check("R8", "not yet after reload", int'(irq), 0);
      cyc("R8");
      check("R8", "fires 3 after reload", int'(irq_id), ND);
      ack_src(ND, "R8");
      repeat (12) cyc("R8");
      check("R8", "stopped after expiry", int'(irq), 0);

      // R9: new edge and acknowledge of the same source on one edge
      req[0] = 1'b1;
      cyc("R2");
      req[0] = 1'b0;
      cyc("R9");
      req[0] = 1'b1;
      ack    = 1'b1;
      ackid  = '0;
      cyc("R9");
      ack = 1'b0;
      check("R9", "set wins over ack", int'(irq_id), 0);
      check("R9", "still requesting", int'(irq), 1);
      ack_src(0, "R9");
      check("R10", "idle id zero", int'(irq_id), 0);
      req = '0;
      cyc("R10");

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   int tval_list[5] = '{0, 1, 2, 5, 37};

endmodule